// File: doc/BRIEF.md
# Bus-Master Disk DMA Register File

This block holds the software-visible registers of a two-channel bus-master disk DMA engine and decodes byte reads and writes from a simple I/O bus. Each channel owns an eight-byte window. The window holds a control byte, a status byte and a 32-bit base address for the descriptor table. The data mover, which sits outside this block, reads the start flag, the transfer direction and the descriptor base from dedicated outputs. It reports faults and completions back through one-cycle set pulses.

The status byte combines three kinds of access. The active flag follows the start bit of the control byte, and software cannot write it through the status byte. The error and interrupt flags are set by the channel and cleared by software writing a one to them. Two drive-capable flags are plain read/write. The padding bytes in the control group read back as all ones and ignore writes.

Read data is combinational from the addressed byte while the read strobe is high. Writes take effect at the next rising clock edge.

Top module: `bmr_regfile`

## Requirements
- R1: After reset every control, status and descriptor byte of every channel reads 0x00, and the start, direction and descriptor outputs are zero.
- R2: Channel c occupies byte addresses 8*c to 8*c+7. Offset 0 is the control byte, offset 2 is the status byte, and offsets 4 to 7 are descriptor base bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R3: A control write keeps only bit 0 (start) and bit 3 (direction); the other bits read as 0. The stored start bit drives ch_start and status bit 0. The stored direction bit drives ch_dir.
- R4: A status write never changes status bit 0.
- R5: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to them in a status write. Writing 0 leaves them unchanged.
- R6: A status write loads bits 5 and 6 directly from the written byte. Bits 3, 4 and 7 always read 0.
- R7: A read of offset 1 or 3 of a window returns 0xFF. A write to those offsets changes no register.
- R8: A descriptor write changes only the addressed byte lane. Descriptor bits 1:0 always read 0. ch_desc_base presents the stored value.
- R9: An err_set pulse sets status bit 1 and an irq_set pulse sets status bit 2. A set wins over a software clear in the same cycle.
- R10: Writes and set pulses for one channel leave every register of the other channel unchanged.
- R11: io_rdata is 0x00 whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W (4) | Byte address on the I/O bus |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the address |
| ev_err_set | input | NUM_CH | Per-channel error set pulse |
| ev_irq_set | input | NUM_CH | Per-channel interrupt set pulse |
| ch_start | output | NUM_CH | Stored start bit per channel |
| ch_dir | output | NUM_CH | Stored direction bit per channel |
| ch_desc_base | output | NUM_CH*32 | Descriptor base per channel, channel 0 in the low word |

## Verification
The assertions assume that io_rd and io_wr are never high together and that io_addr is stable while a strobe is high. The padding-write property also assumes that no set pulse arrives in the same cycle as the write it checks. The stimulus changes the inputs only on falling edges and raises one strobe at a time. Set pulses are driven either alone or together with a status write to the same channel, so both the plain set case and the set-versus-clear case are covered.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
   localparam int WIN_BYTES   = 8;
   localparam int DESC_BITS   = 32;
   localparam int LANES       = DESC_BITS / 8;
   localparam logic [1:0] OFF_CTRL = 2'd0;
   localparam logic [1:0] OFF_STAT = 2'd2;
   localparam logic [7:0] CTRL_KEEP   = 8'h09;
   localparam logic [7:0] PAD_BYTE    = 8'hFF;
   localparam int BIT_START = 0;
   localparam int BIT_DIR   = 3;
   localparam int BIT_ACT   = 0;
   localparam int BIT_ERR   = 1;
   localparam int BIT_IRQ   = 2;
   localparam int BIT_RW_LO = 5;
   localparam int BIT_RW_HI = 6;
endpackage

// File: rtl/bmr_chan_regs.sv
module bmr_chan_regs
   import bmr_pkg::*;
#(
   parameter int ALIGN_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_stat,
   input  logic [LANES-1:0] wr_desc,
   input  logic [7:0]       wdata,
   input  logic             err_set,
   input  logic             irq_set,
   output logic [7:0]       ctrl_q,
   output logic [7:0]       stat_q,
   output logic [DESC_BITS-1:0] desc_q
);
   if (ALIGN_BITS < 0 || ALIGN_BITS > 7) begin : g_bad_align
      $error("ALIGN_BITS must be 0..7");
   end

   logic       start_r, dir_r, err_r, irq_r;
   logic [1:0] drv_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_r <= 1'b0;
         dir_r   <= 1'b0;
      end else if (wr_ctrl) begin
         start_r <= wdata[BIT_START];
         dir_r   <= wdata[BIT_DIR];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_r <= 1'b0;
         irq_r <= 1'b0;
         drv_r <= 2'b00;
      end else begin
         if (err_set)
            err_r <= 1'b1;
         else if (wr_stat && wdata[BIT_ERR])
            err_r <= 1'b0;
         if (irq_set)
            irq_r <= 1'b1;
         else if (wr_stat && wdata[BIT_IRQ])
            irq_r <= 1'b0;
         if (wr_stat)
            drv_r <= wdata[BIT_RW_HI:BIT_RW_LO];
      end
   end

   always_comb begin
      ctrl_q = '0;
      ctrl_q[BIT_START] = start_r;
      ctrl_q[BIT_DIR]   = dir_r;
      stat_q = '0;
      stat_q[BIT_ACT]   = start_r;
      stat_q[BIT_ERR]   = err_r;
      stat_q[BIT_IRQ]   = irq_r;
      stat_q[BIT_RW_HI:BIT_RW_LO] = drv_r;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0 && ALIGN_BITS > 0) begin : g_aligned
         logic [7-ALIGN_BITS:0] hi_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          hi_r <= '0;
            else if (wr_desc[l]) hi_r <= wdata[7:ALIGN_BITS];
         end
         assign desc_q[7:0] = {hi_r, {ALIGN_BITS{1'b0}}};
      end else begin : g_full
         logic [7:0] byte_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          byte_r <= '0;
            else if (wr_desc[l]) byte_r <= wdata;
         end
         assign desc_q[l*8 +: 8] = byte_r;
      end

      a_r8_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_desc[l] |=> $stable(desc_q[l*8 +: 8]));
   end

   a_r3_start_to_active: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> stat_q[BIT_ACT] == $past(wdata[BIT_START]));
   a_r4_stat_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wr_ctrl) |=> $stable(stat_q[BIT_ACT]));
   a_r9_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> stat_q[BIT_ERR]);
   a_r9_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> stat_q[BIT_IRQ]);
   a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[BIT_ERR] && !err_set) |=> !stat_q[BIT_ERR]);
   a_r5_irq_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wdata[BIT_IRQ] && !irq_set) |=> $stable(stat_q[BIT_IRQ]));
endmodule

// File: rtl/bmr_rd_mux.sv
module bmr_rd_mux
   import bmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_CH*8-1:0]         ctrl_i,
   input  logic [NUM_CH*8-1:0]         stat_i,
   input  logic [NUM_CH*DESC_BITS-1:0] desc_i,
   output logic [7:0]                  rdata_o
);
   localparam int IDX_W = ADDR_W - 3;

   logic [IDX_W-1:0] win;
   logic [2:0]       off;

   assign win = addr[ADDR_W-1:3];
   assign off = addr[2:0];

   always_comb begin
      rdata_o = PAD_BYTE;
      for (int c = 0; c < NUM_CH; c++) begin
         if (win == IDX_W'(c)) begin
            if (off[2]) begin
               rdata_o = desc_i[c*DESC_BITS + int'({off[1:0], 3'b000}) +: 8];
            end else begin
               case (off[1:0])
                  OFF_CTRL: rdata_o = ctrl_i[c*8 +: 8];
                  OFF_STAT: rdata_o = stat_i[c*8 +: 8];
                  default:  rdata_o = PAD_BYTE;
               endcase
            end
         end
      end
      if (!rd_en) rdata_o = 8'h00;
   end
endmodule

// File: rtl/bmr_regfile.sv
module bmr_regfile
   import bmr_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int ADDR_W     = 4,
   parameter int ALIGN_BITS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           io_addr,
   input  logic                        io_wr,
   input  logic                        io_rd,
   input  logic [7:0]                  io_wdata,
   output logic [7:0]                  io_rdata,
   input  logic [NUM_CH-1:0]           ev_err_set,
   input  logic [NUM_CH-1:0]           ev_irq_set,
   output logic [NUM_CH-1:0]           ch_start,
   output logic [NUM_CH-1:0]           ch_dir,
   output logic [NUM_CH*DESC_BITS-1:0] ch_desc_base
);
   localparam int IDX_W = ADDR_W - 3;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (ADDR_W < 4 || (1 << IDX_W) < NUM_CH) begin : g_bad_addr
      $error("ADDR_W too small for NUM_CH windows");
   end

   logic [IDX_W-1:0]        win;
   logic [2:0]              off;
   logic [NUM_CH*8-1:0]     ctrl_all, stat_all;

   assign win = io_addr[ADDR_W-1:3];
   assign off = io_addr[2:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic             hit, w_ctrl, w_stat;
      logic [LANES-1:0] w_desc;

      assign hit    = io_wr && (win == IDX_W'(c));
      assign w_ctrl = hit && !off[2] && (off[1:0] == OFF_CTRL);
      assign w_stat = hit && !off[2] && (off[1:0] == OFF_STAT);
      for (genvar l = 0; l < LANES; l++) begin : g_dec
         assign w_desc[l] = hit && off[2] && (off[1:0] == 2'(l));
      end

      bmr_chan_regs #(.ALIGN_BITS(ALIGN_BITS)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctrl (w_ctrl),
         .wr_stat (w_stat),
         .wr_desc (w_desc),
         .wdata   (io_wdata),
         .err_set (ev_err_set[c]),
         .irq_set (ev_irq_set[c]),
         .ctrl_q  (ctrl_all[c*8 +: 8]),
         .stat_q  (stat_all[c*8 +: 8]),
         .desc_q  (ch_desc_base[c*DESC_BITS +: DESC_BITS])
      );

      assign ch_start[c] = ctrl_all[c*8 + BIT_START];
      assign ch_dir[c]   = ctrl_all[c*8 + BIT_DIR];
   end

   bmr_rd_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
      .rd_en   (io_rd),
      .addr    (io_addr),
      .ctrl_i  (ctrl_all),
      .stat_i  (stat_all),
      .desc_i  (ch_desc_base),
      .rdata_o (io_rdata)
   );

   a_r7_pad_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !off[2] && off[0]) |-> io_rdata == PAD_BYTE);
   a_r7_pad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !off[2] && off[0] && ev_err_set == '0 && ev_irq_set == '0)
      |=> ($stable(ctrl_all) && $stable(stat_all)));
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> io_rdata == 8'h00);
endmodule

// File: tb/bmr_regfile_test.sv
module bmr_regfile_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        io_addr = '0;
   logic              io_wr = 1'b0;
   logic              io_rd = 1'b0;
   logic [7:0]        io_wdata = '0;
   logic [7:0]        io_rdata;
   logic [NCH-1:0]    ev_err_set = '0;
   logic [NCH-1:0]    ev_irq_set = '0;
   logic [NCH-1:0]    ch_start, ch_dir;
   logic [NCH*32-1:0] ch_desc_base;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   typedef struct {
      logic [3:0] addr;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb[$];
   event  sample_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmr_regfile uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .ev_err_set(ev_err_set),
      .ev_irq_set(ev_irq_set), .ch_start(ch_start), .ch_dir(ch_dir),
      .ch_desc_base(ch_desc_base)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when the driver flags a sampled read
   always @(sample_ev) begin
      item_t it;
      if (sb.size() == 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual=empty expected=item");
      end else begin
         it = sb.pop_front();
         check($sformatf("%s addr=%0h", it.tag, it.addr), {24'h0, io_rdata}, {24'h0, it.exp});
      end
   end

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      sb.push_back('{addr: a, exp: exp, tag: tag});
      #(CLK_PERIOD/4);
      -> sample_ev;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d,
                     input logic [NCH-1:0] e, input logic [NCH-1:0] q);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      ev_err_set = e; ev_irq_set = q;
      @(negedge clk);
      io_wr = 1'b0; ev_err_set = '0; ev_irq_set = '0;
   endtask

   task automatic pulse(input logic [NCH-1:0] e, input logic [NCH-1:0] q);
      @(negedge clk);
      ev_err_set = e; ev_irq_set = q;
      @(negedge clk);
      ev_err_set = '0; ev_irq_set = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R11 idle read
      check("R11 idle rdata", {24'h0, io_rdata}, 32'h0);
      check("R1 ch_start", {30'h0, ch_start}, 32'h0);
      check("R1 desc", ch_desc_base[31:0], 32'h0);
      rd(4'h0, 8'h00, "R1 ctrl0");
      rd(4'h2, 8'h00, "R1 stat0");
      rd(4'h7, 8'h00, "R1 desc0");
      rd(4'hA, 8'h00, "R1 stat1");
      // R7 padding reads
      rd(4'h1, 8'hFF, "R7 pad1");
      rd(4'h3, 8'hFF, "R7 pad3");
      rd(4'hB, 8'hFF, "R7 pad ch1");
      // R3 control write
      wr(4'h0, 8'hFF, '0, '0);
      rd(4'h0, 8'h09, "R3 ctrl keep");
      rd(4'h2, 8'h01, "R3 active");
      check("R3 ch_start", {30'h0, ch_start}, 32'h1);
      check("R3 ch_dir", {30'h0, ch_dir}, 32'h1);
      // R4 status write keeps active
      wr(4'h2, 8'h00, '0, '0);
      rd(4'h2, 8'h01, "R4 active kept 0 write");
      // R6 direct bits, reserved zero
      wr(4'h2, 8'hFF, '0, '0);
      rd(4'h2, 8'h61, "R6 rw bits");
      wr(4'h0, 8'h00, '0, '0);
      rd(4'h2, 8'h60, "R3 stop clears active");
      // R9 set pulses
      pulse(2'b01, 2'b00);
      rd(4'h2, 8'h62, "R9 err set");
      pulse(2'b00, 2'b01);
      rd(4'h2, 8'h66, "R9 irq set");
      // R5 write one to clear
      wr(4'h2, 8'h02, '0, '0);
      rd(4'h2, 8'h04, "R5 clear err keep irq");
      wr(4'h2, 8'h60, '0, '0);
      rd(4'h2, 8'h64, "R5 zero keeps irq");
      // R9 set beats clear
      wr(4'h2, 8'h64, 2'b00, 2'b01);
      rd(4'h2, 8'h64, "R9 set wins");
      // R7 padding writes ignored
      wr(4'h1, 8'hFF, '0, '0);
      wr(4'h3, 8'hFF, '0, '0);
      rd(4'h0, 8'h00, "R7 ctrl unchanged");
      rd(4'h2, 8'h64, "R7 stat unchanged");
      // R8 descriptor lanes, R2 byte order
      wr(4'h4, 8'hFF, '0, '0);
      rd(4'h4, 8'hFC, "R8 align");
      wr(4'h5, 8'h12, '0, '0);
      wr(4'h6, 8'h34, '0, '0);
      wr(4'h7, 8'h56, '0, '0);
      check("R2 desc order", ch_desc_base[31:0], 32'h563412FC);
      wr(4'h5, 8'hAB, '0, '0);
      check("R8 lane only", ch_desc_base[31:0], 32'h5634ABFC);
      rd(4'h6, 8'h34, "R8 lane read");
      // R10 channel isolation
      rd(4'h8, 8'h00, "R10 ch1 ctrl");
      check("R10 ch1 desc", ch_desc_base[63:32], 32'h0);
      wr(4'h8, 8'h01, '0, '0);
      pulse(2'b10, 2'b00);
      rd(4'hA, 8'h03, "R10 ch1 stat");
      rd(4'h2, 8'h64, "R10 ch0 stat");
      wr(4'hF, 8'h9A, '0, '0);
      check("R10 ch1 desc top", ch_desc_base[63:32], 32'h9A000000);
      check("R10 ch0 desc", ch_desc_base[31:0], 32'h5634ABFC);
      check("R3 ch_start both", {30'h0, ch_start}, 32'h2);
      repeat (2) @(negedge clk);
      check("scoreboard drained", sb.size(), 0);
      finish_run();
   end
endmodule